// File: doc/BRIEF.md
# Preloadable 8-bit Timer / Event Counter

This block is an 8-bit up-counter with a reload register. Each counting event adds one to the count. When the count is at all-ones, the next event wraps it back to the reload value and raises an interrupt pulse. Software programs the block through a two-register window, a control byte and a reload byte, and can read the live count at any time.

Three operating modes are available. In internal-timer mode, the counter advances on system-clock cycles, or on strobes from a slower auxiliary tick, after a power-of-two prescaler. In event mode, it counts one selected edge of an external pin. In pulse-width mode, it counts system-clock cycles while the pin sits at a chosen level, and then stops itself so the result can be read. The pin is resynchronized inside the block.

Top module: `tmr8_evcnt`

## Requirements
- R1: After reset, the control byte reads 0x00, the count reads 0x00 and `irq_o` is low.
- R2: Register map. Address 0 is the control byte, which reads back what was written. Address 1 writes the reload register and reads the live count. Control fields are: [7:6] mode (00 idle, 01 pin event, 10 internal timer, 11 pulse width), [5] timer tick source (1 = `alt_tick_i`, 0 = every clock), [4] run, [3] edge/level select, [2:0] prescale exponent n.
- R3: In timer mode with run set, the count advances once every 2^n source ticks. The first advance comes on the 2^n-th tick after run is set.
- R4: An event that arrives while the count is 0xFF loads the reload value into the count. `irq_o` is high for exactly the one cycle after that event.
- R5: A reload write while run is 0 also loads the written value into the count on the next cycle.
- R6: A reload write while run is 1 leaves the count untouched. The new value first takes effect at the next wrap.
- R7: When a reload write lands in the same cycle as a wrap, the count is loaded with the value being written.
- R8: In event mode, bit 3 = 0 counts rising pin edges and bit 3 = 1 counts falling pin edges. An edge shows in the count on the third clock edge after the pin changes.
- R9: In event mode the prescale field has no effect.
- R10: With bit 5 set in timer mode, only `alt_tick_i` strobes feed the prescaler.
- R11: In pulse-width mode, the count grows by one per clock cycle that the synchronized pin spends at its active level. The active level is high when bit 3 = 1 and low when bit 3 = 0.
- R12: In pulse-width mode, the edge that ends the active level clears the run bit, and later pulses are not counted.
- R13: With run at 0, or with mode 00, the count holds except for a reload write made while stopped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| alt_tick_i | input | 1 | One-cycle strobe from a slow auxiliary time base |
| pin_i | input | 1 | Asynchronous external count/gate pin |
| bus_we_i | input | 1 | Register write strobe |
| bus_addr_i | input | 1 | Register select: 0 control, 1 reload/count |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data for the selected register |
| irq_o | output | 1 | One-cycle wrap interrupt pulse |

## Verification
A write to the reload register and a counter wrap can fall in the same clock cycle. The bench provokes this by starting the timer at divide-by-one from 0xFE and issuing the write in the cycle where the count sits at 0xFF. That cycle must show the newly written value in the count together with `irq_o`, and the following cycle must show that value plus one with `irq_o` low. The pulse-width stop edge that clears run is a second self-modifying path. The bench judges it by reading the control byte back once the measured pulse has ended.

// File: rtl/tmr8_pkg.sv
package tmr8_pkg;

  localparam int CTRL_W = 8;

  typedef enum logic [1:0] {
    MODE_IDLE  = 2'b00,
    MODE_EVENT = 2'b01,
    MODE_TIMER = 2'b10,
    MODE_PULSE = 2'b11
  } tmr_mode_e;

  // Packed MSB first: [7:6] mode, [5] alt source, [4] run, [3] edge, [2:0] prescale
  typedef struct packed {
    tmr_mode_e  mode;
    logic       alt_src;
    logic       run;
    logic       edge_sel;
    logic [2:0] psc;
  } tmr_ctrl_t;

endpackage

// File: rtl/tmr8_prescale.sv
module tmr8_prescale #(
  parameter int PSC_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             src_tick_i,
  input  logic [PSC_W-1:0] sel_i,
  output logic             tick_o
);

  localparam int DIV_W = (1 << PSC_W) - 1;

  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] div_d;
  logic [DIV_W-1:0] mask;

  // Low n bits of the divider must be all ones for a tick.
  always_comb begin
    for (int b = 0; b < DIV_W; b++) begin
      mask[b] = (b < int'(sel_i));
    end
  end

  assign tick_o = src_tick_i && ((div_q & mask) == mask);

  always_comb begin
    div_d = div_q;
    if (clr_i) begin
      div_d = '0;
    end else if (src_tick_i) begin
      div_d = div_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q <= '0;
    end else begin
      div_q <= div_d;
    end
  end

endmodule

// File: rtl/tmr8_pin_edge.sv
module tmr8_pin_edge #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  output logic rise_o,
  output logic fall_o
);

  logic [SYNC_STAGES-1:0] sync_q;
  logic [SYNC_STAGES-1:0] sync_d;
  logic                   hist_q;

  always_comb begin
    sync_d[0] = pin_i;
    for (int s = 1; s < SYNC_STAGES; s++) begin
      sync_d[s] = sync_q[s-1];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      hist_q <= 1'b0;
    end else begin
      sync_q <= sync_d;
      hist_q <= sync_q[SYNC_STAGES-1];
    end
  end

  assign rise_o = sync_q[SYNC_STAGES-1] && !hist_q;
  assign fall_o = !sync_q[SYNC_STAGES-1] && hist_q;

endmodule

// File: rtl/tmr8_count_core.sv
module tmr8_count_core #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         step_i,
  input  logic         running_i,
  input  logic         pre_we_i,
  input  logic [W-1:0] pre_wdata_i,
  output logic [W-1:0] count_o,
  output logic         wrap_o
);

  logic [W-1:0] count_q, count_d;
  logic [W-1:0] preload_q, preload_d;
  logic         wrap_q;
  logic         at_full;
  logic         wrap_now;

  assign at_full  = &count_q;
  assign wrap_now = step_i && at_full;

  // A reload write in the wrap cycle is forwarded into the count.
  assign preload_d = pre_we_i ? pre_wdata_i : preload_q;

  always_comb begin
    count_d = count_q;
    if (wrap_now) begin
      count_d = preload_d;
    end else if (step_i) begin
      count_d = count_q + 1'b1;
    end else if (pre_we_i && !running_i) begin
      count_d = pre_wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      count_q   <= '0;
      preload_q <= '0;
      wrap_q    <= 1'b0;
    end else begin
      count_q   <= count_d;
      preload_q <= preload_d;
      wrap_q    <= wrap_now;
    end
  end

  assign count_o = count_q;
  assign wrap_o  = wrap_q;

endmodule

// File: rtl/tmr8_evcnt.sv
module tmr8_evcnt
  import tmr8_pkg::*;
#(
  parameter int W           = 8,
  parameter int PSC_W       = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         alt_tick_i,
  input  logic         pin_i,
  input  logic         bus_we_i,
  input  logic         bus_addr_i,
  input  logic [W-1:0] bus_wdata_i,
  output logic [W-1:0] bus_rdata_o,
  output logic         irq_o
);

  tmr_ctrl_t ctrl_q, ctrl_d;
  logic      pw_active_q, pw_active_d;

  logic         wr_ctrl, wr_pre;
  logic         src_tick, psc_clr, psc_tick;
  logic         pin_rise, pin_fall;
  logic         start_edge, stop_edge;
  logic         pw_mode, pw_start, pw_stop;
  logic         step;
  logic [W-1:0] count;

  assign wr_ctrl = bus_we_i && !bus_addr_i;
  assign wr_pre  = bus_we_i && bus_addr_i;

  // Internal time base.
  assign src_tick = ctrl_q.alt_src ? alt_tick_i : 1'b1;
  assign psc_clr  = !ctrl_q.run || (ctrl_q.mode != MODE_TIMER);

  tmr8_prescale #(.PSC_W(PSC_W)) u_psc (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (psc_clr),
    .src_tick_i(src_tick),
    .sel_i     (ctrl_q.psc),
    .tick_o    (psc_tick)
  );

  // External pin conditioning.
  tmr8_pin_edge #(.SYNC_STAGES(SYNC_STAGES)) u_pin (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .pin_i (pin_i),
    .rise_o(pin_rise),
    .fall_o(pin_fall)
  );

  // Pulse-width gating.
  assign start_edge = ctrl_q.edge_sel ? pin_rise : pin_fall;
  assign stop_edge  = ctrl_q.edge_sel ? pin_fall : pin_rise;
  assign pw_mode    = ctrl_q.run && (ctrl_q.mode == MODE_PULSE);
  assign pw_start   = pw_mode && !pw_active_q && start_edge;
  assign pw_stop    = pw_mode && pw_active_q && stop_edge;

  always_comb begin
    pw_active_d = pw_active_q;
    if (!pw_mode || pw_stop) begin
      pw_active_d = 1'b0;
    end else if (pw_start) begin
      pw_active_d = 1'b1;
    end
  end

  // Event selection per mode.
  always_comb begin
    step = 1'b0;
    unique case (ctrl_q.mode)
      MODE_TIMER: step = ctrl_q.run && psc_tick;
      MODE_EVENT: step = ctrl_q.run && (ctrl_q.edge_sel ? pin_fall : pin_rise);
      MODE_PULSE: step = pw_start || (pw_mode && pw_active_q && !stop_edge);
      default:    step = 1'b0;
    endcase
  end

  // Control register: software write wins over the self-clear.
  always_comb begin
    ctrl_d = ctrl_q;
    if (wr_ctrl) begin
      ctrl_d = tmr_ctrl_t'(bus_wdata_i[CTRL_W-1:0]);
    end else if (pw_stop) begin
      ctrl_d.run = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q      <= '0;
      pw_active_q <= 1'b0;
    end else begin
      ctrl_q      <= ctrl_d;
      pw_active_q <= pw_active_d;
    end
  end

  tmr8_count_core #(.W(W)) u_core (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .step_i     (step),
    .running_i  (ctrl_q.run),
    .pre_we_i   (wr_pre),
    .pre_wdata_i(bus_wdata_i),
    .count_o    (count),
    .wrap_o     (irq_o)
  );

  assign bus_rdata_o = bus_addr_i ? count : W'(ctrl_q);

endmodule

// File: rtl/tmr8_evcnt_chk.sv
module tmr8_evcnt_chk #(
  parameter int W = 8
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         bus_we_i,
  input logic         bus_addr_i,
  input logic [W-1:0] bus_wdata_i,
  input logic [7:0]   ctrl_i,
  input logic [W-1:0] count_i,
  input logic [W-1:0] preload_i,
  input logic         irq_i
);

  logic wr_pre;
  logic run;
  logic idle;

  assign wr_pre = bus_we_i && bus_addr_i;
  assign run    = ctrl_i[4];
  assign idle   = (ctrl_i[7:6] == 2'b00);

  // R4
  wrap_from_full_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_i |-> ($past(count_i) == {W{1'b1}}));

  // R4
  reload_value_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_i && !$past(wr_pre)) |-> (count_i == preload_i));

  // R5
  stopped_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_pre && !run) |=> (count_i == $past(bus_wdata_i)));

  // R6
  running_defer_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_pre && run && (count_i != {W{1'b1}})) |=>
      ((count_i == $past(count_i)) || (count_i == W'($past(count_i) + 1'b1))));

  // R13
  hold_count_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((!run || idle) && !wr_pre) |=> $stable(count_i));

endmodule

bind tmr8_evcnt tmr8_evcnt_chk #(.W(W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .bus_we_i   (bus_we_i),
  .bus_addr_i (bus_addr_i),
  .bus_wdata_i(bus_wdata_i),
  .ctrl_i     (ctrl_q),
  .count_i    (count),
  .preload_i  (u_core.preload_q),
  .irq_i      (irq_o)
);

// File: tb/tmr8_evcnt_tb.sv
`timescale 1ns/1ps
module tmr8_evcnt_tb;

  logic       clk;
  logic       rst_n;
  logic       alt_tick;
  logic       pin;
  logic       we;
  logic       addr;
  logic [7:0] wdata;
  logic [7:0] rdata;
  logic       irq;

  int n_checks = 0;
  int n_fail   = 0;

  tmr8_evcnt u_dut (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .alt_tick_i (alt_tick),
    .pin_i      (pin),
    .bus_we_i   (we),
    .bus_addr_i (addr),
    .bus_wdata_i(wdata),
    .bus_rdata_o(rdata),
    .irq_o      (irq)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // {prescale exponent, reload, clock cycles run, expected count}
  localparam logic [34:0] VEC [6] = '{
    {3'd0, 8'h10, 16'd20,  8'h24},
    {3'd1, 8'h00, 16'd9,   8'h04},
    {3'd3, 8'h20, 16'd40,  8'h25},
    {3'd7, 8'h00, 16'd300, 8'h02},
    {3'd0, 8'hF0, 16'd20,  8'hF4},
    {3'd2, 8'hFE, 16'd10,  8'hFE}
  };

  task automatic check(input string req, input int actual, input int expected);
    n_checks++;
    if (actual != expected) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, actual, expected);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic a, output logic [7:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic pin_pattern();
    pin = 1'b1; repeat (5) @(negedge clk);
    pin = 1'b0; repeat (5) @(negedge clk);
    pin = 1'b1; repeat (5) @(negedge clk);
    pin = 1'b0; repeat (5) @(negedge clk);
    pin = 1'b1; repeat (5) @(negedge clk);
  endtask

  initial begin
    #(4 * 150000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [7:0] v;
    logic [2:0] psc;
    logic [7:0] pre;
    logic [15:0] cyc;
    logic [7:0] exp_cnt;

    rst_n = 1'b0; alt_tick = 1'b0; pin = 1'b0;
    we = 1'b0; addr = 1'b0; wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(1'b0, v); check("R1", v, 8'h00);
    rd(1'b1, v); check("R1", v, 8'h00);
    check("R1", irq, 0);

    // R3 timer vectors (R4 wrap in entries 4 and 5)
    for (int i = 0; i < 6; i++) begin
      {psc, pre, cyc, exp_cnt} = VEC[i];
      wr(1'b0, 8'h00);
      wr(1'b1, pre);
      rd(1'b1, v); check("R5", v, pre);
      wr(1'b0, {2'b10, 1'b0, 1'b1, 1'b0, psc});
      repeat (int'(cyc)) @(negedge clk);
      rd(1'b1, v); check("R3", v, exp_cnt);
    end

    // R6 deferred reload, R4 wrap pulse
    wr(1'b0, 8'h00);
    wr(1'b1, 8'hFD);
    wr(1'b0, 8'h90);
    @(negedge clk);
    wr(1'b1, 8'h40);
    rd(1'b1, v); check("R6", v, 8'hFF);
    @(negedge clk);
    rd(1'b1, v); check("R4", v, 8'h40);
    check("R4", irq, 1);
    @(negedge clk);
    rd(1'b1, v); check("R4", v, 8'h41);
    check("R4", irq, 0);

    // R7 reload write coinciding with wrap
    wr(1'b0, 8'h00);
    wr(1'b1, 8'hFE);
    wr(1'b0, 8'h90);
    @(negedge clk);
    wr(1'b1, 8'h77);
    rd(1'b1, v); check("R7", v, 8'h77);
    check("R7", irq, 1);
    @(negedge clk);
    rd(1'b1, v); check("R7", v, 8'h78);
    check("R7", irq, 0);

    // R8 synchronizer latency on a rising edge
    wr(1'b0, 8'h00);
    wr(1'b1, 8'h00);
    repeat (4) @(negedge clk);
    wr(1'b0, 8'h50);
    pin = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rd(1'b1, v); check("R8", v, 8'h00);
    @(negedge clk);
    rd(1'b1, v); check("R8", v, 8'h01);

    // R8 rising edges with prescale 7 (R9)
    wr(1'b0, 8'h00);
    pin = 1'b0; repeat (5) @(negedge clk);
    wr(1'b1, 8'h00);
    wr(1'b0, 8'h57);
    pin_pattern();
    rd(1'b1, v); check("R9", v, 8'h03);

    // R8 falling edges
    wr(1'b0, 8'h00);
    pin = 1'b0; repeat (5) @(negedge clk);
    wr(1'b1, 8'h00);
    wr(1'b0, 8'h5F);
    pin_pattern();
    rd(1'b1, v); check("R8", v, 8'h02);

    // R10 auxiliary tick source, divide by two
    wr(1'b0, 8'h00);
    wr(1'b1, 8'h00);
    wr(1'b0, 8'hB1);
    for (int k = 0; k < 6; k++) begin
      alt_tick = 1'b1; @(negedge clk);
      alt_tick = 1'b0; repeat (2) @(negedge clk);
    end
    rd(1'b1, v); check("R10", v, 8'h03);

    // R11 pulse width, active high; R12 self stop
    wr(1'b0, 8'h00);
    pin = 1'b0; repeat (5) @(negedge clk);
    wr(1'b1, 8'h00);
    wr(1'b0, 8'hD8);
    pin = 1'b1; repeat (10) @(negedge clk);
    pin = 1'b0; repeat (6) @(negedge clk);
    rd(1'b1, v); check("R11", v, 8'h0A);
    rd(1'b0, v); check("R12", v, 8'hC8);
    pin = 1'b1; repeat (5) @(negedge clk);
    pin = 1'b0; repeat (5) @(negedge clk);
    rd(1'b1, v); check("R12", v, 8'h0A);

    // R11 pulse width, active low
    wr(1'b0, 8'h00);
    pin = 1'b1; repeat (5) @(negedge clk);
    wr(1'b1, 8'h00);
    wr(1'b0, 8'hD0);
    pin = 1'b0; repeat (7) @(negedge clk);
    pin = 1'b1; repeat (6) @(negedge clk);
    rd(1'b1, v); check("R11", v, 8'h07);
    rd(1'b0, v); check("R12", v, 8'hC0);

    // R13 idle mode with run set, R2 control readback
    wr(1'b0, 8'h00);
    wr(1'b1, 8'h33);
    wr(1'b0, 8'h17);
    rd(1'b0, v); check("R2", v, 8'h17);
    pin_pattern();
    repeat (20) @(negedge clk);
    rd(1'b1, v); check("R13", v, 8'h33);
    wr(1'b1, 8'h55);
    rd(1'b1, v); check("R13", v, 8'h33);
    check("R13", irq, 0);

    finish_run();
  end

endmodule